// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

This block keeps one private cache coherent with its neighbours on a shared, atomic snooping bus. It holds a three-state coherence entry (Invalid, Shared, Exclusive) and a tag for each line of a direct-mapped array. It does not hold the data array. A processor access that hits completes without touching the bus. A miss, or a write to a line held clean, asks an arbiter for the bus. Once the bus is granted, the controller places a read miss or a write miss on it. If the miss would displace a dirty line, a write-back of that line goes out first.

At the same time the controller watches every transaction that the other caches place on the bus. A write miss that names a block it holds removes its copy. A read or write miss that names a block it holds dirty makes it drive `supplied`, which tells memory to stand down while this cache provides the block. Snoops take priority over the processor for the state array. A pending miss whose line is changed by a snoop while it waits for the bus goes back and re-evaluates the line from scratch. The controller changes a line for the processor only after it has won the bus.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line reads back as Invalid (state code 2'b00), and `busReq` and `cpuDone` are low.
- R2: A processor read whose line is Invalid or holds another tag places a read miss (command 2'b01) with the processor address on the bus, and the line becomes Shared (2'b01) with the new tag.
- R3: A processor write whose line is Invalid, or Shared with the same tag, places a write miss (command 2'b10) with the processor address, and the line becomes Exclusive (2'b10).
- R4: Read hits in Shared or Exclusive, and write hits in Exclusive, finish with a one-cycle `cpuDone` pulse and never raise `busReq`.
- R5: When a miss displaces an Exclusive line with a different tag, a write-back (command 2'b11) carrying the old tag and index is placed first. The miss follows in the next cycle, and the line ends with the new tag.
- R6: A snooped write miss whose address matches a Shared line turns that line Invalid.
- R7: A snooped read miss whose address matches an Exclusive line raises `supplied` in the same cycle and turns the line Shared. A snooped write miss that matches an Exclusive line raises `supplied` and turns the line Invalid. A snooped miss with a different tag changes nothing and does not raise `supplied`.
- R8: The controller drives a bus transaction only while `busReq` and `busGnt` are both high. A line keeps its state and tag while its request waits for the grant.
- R9: If a snoop changes the line of a pending request before the grant, the request restarts and is decided on the new state. A write that was waiting behind a dirty line that a snooped read has cleaned issues no write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until `cpuDone` |
| cpuWrite | input | 1 | 1 for a write, 0 for a read |
| cpuAddr | input | ADDR_W | Processor block address (tag above index) |
| cpuDone | output | 1 | One-cycle completion pulse |
| busReq | output | 1 | Request to the bus arbiter |
| busGnt | input | 1 | Grant from the bus arbiter |
| busValidOut | output | 1 | This cache drives a bus transaction this cycle |
| busCmdOut | output | 2 | 01 read miss, 10 write miss, 11 write-back |
| busAddrOut | output | ADDR_W | Block address of the transaction |
| snoopValid | input | 1 | Another cache's transaction is on the bus |
| snoopCmd | input | 2 | Command of the snooped transaction |
| snoopAddr | input | ADDR_W | Address of the snooped transaction |
| supplied | output | 1 | This cache provides the dirty block; memory stands down |
| probeIdx | input | INDEX_W | Line selected for state lookup |
| probeState | output | 2 | State of the selected line |
| probeTag | output | ADDR_W-INDEX_W | Tag of the selected line |

## Verification
The checker assumes the arbiter grants the bus to one cache at a time. It also assumes the grant is held for as long as `busReq` stays high, so a write-back and the miss after it go out back to back. It further assumes that a snooped transaction appears only while another cache owns the bus, so a snoop never coincides with this cache's own grant. The bench keeps to these assumptions with a small arbiter that hands out one grant at a time and keeps it until the request drops. Its snoop inputs are wired to the other controller's bus outputs. It also has a switch that holds back the grant to one cache, so that a snoop can strike while that cache's request waits.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10
  } lineState_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'b00,
    BC_RDMISS = 2'b01,
    BC_WRMISS = 2'b10,
    BC_WBACK  = 2'b11
  } busCmd_e;

  // strobes from control to the line-state datapath
  typedef struct packed {
    logic fill;       // write cpu tag and a new state into the cpu line
    logic fillExc;    // new state is Exclusive (else Shared)
    logic selVictim;  // bus address is the resident line, not the cpu address
  } ctlStrobe_t;

endpackage

// File: rtl/coh_datapath.sv
module coh_datapath
  import coh_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INDEX_W = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cpuWrite,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic                      snoopValid,
  input  logic [1:0]                snoopCmd,
  input  logic [ADDR_W-1:0]         snoopAddr,
  input  ctlStrobe_t                strb,
  input  logic [INDEX_W-1:0]        probeIdx,
  output logic                      cpuHit,
  output logic                      victimDirty,
  output logic                      restart,
  output logic                      supplied,
  output logic [ADDR_W-1:0]         busAddr,
  output logic [1:0]                probeState,
  output logic [ADDR_W-INDEX_W-1:0] probeTag
);

  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W;

  lineState_e       stateQ [LINES];
  logic [TAG_W-1:0] tagQ   [LINES];

  logic [INDEX_W-1:0] cpuIdx, snIdx;
  logic [TAG_W-1:0]   cpuTag, snTag;
  lineState_e         cpuState, snState, snNext;
  logic               tagHit, snMatch, snChange;

  assign cpuIdx = cpuAddr[INDEX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:INDEX_W];
  assign snIdx  = snoopAddr[INDEX_W-1:0];
  assign snTag  = snoopAddr[ADDR_W-1:INDEX_W];

  assign cpuState = stateQ[cpuIdx];
  assign snState  = stateQ[snIdx];

  // cpu side lookup
  assign tagHit      = (cpuState != LS_INV) && (tagQ[cpuIdx] == cpuTag);
  assign cpuHit      = tagHit && (!cpuWrite || cpuState == LS_EXC);
  assign victimDirty = (cpuState == LS_EXC) && (tagQ[cpuIdx] != cpuTag);
  assign busAddr     = strb.selVictim ? {tagQ[cpuIdx], cpuIdx} : cpuAddr;

  // snoop side lookup
  assign snMatch = snoopValid
                && (snoopCmd == BC_RDMISS || snoopCmd == BC_WRMISS)
                && (snState != LS_INV) && (tagQ[snIdx] == snTag);

  always_comb begin
    snNext = snState;
    if (snoopCmd == BC_WRMISS)     snNext = LS_INV;
    else if (snState == LS_EXC)    snNext = LS_SHR;
  end

  assign snChange = snMatch && (snNext != snState);
  assign supplied = snMatch && (snState == LS_EXC);
  assign restart  = snChange && (snIdx == cpuIdx);

  // state array: snoop update written last so it wins on a shared index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stateQ[i] <= LS_INV;
        tagQ[i]   <= '0;
      end
    end else begin
      if (strb.fill) begin
        stateQ[cpuIdx] <= strb.fillExc ? LS_EXC : LS_SHR;
        tagQ[cpuIdx]   <= cpuTag;
      end
      if (snChange) stateQ[snIdx] <= snNext;
    end
  end

  assign probeState = stateQ[probeIdx];
  assign probeTag   = tagQ[probeIdx];

endmodule

// File: rtl/coh_control.sv
module coh_control
  import coh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWrite,
  input  logic       cpuHit,
  input  logic       victimDirty,
  input  logic       restart,
  input  logic       snoopValid,
  input  logic       busGnt,
  output ctlStrobe_t strb,
  output logic       busReq,
  output logic       busValid,
  output logic [1:0] busCmd,
  output logic       cpuDone
);

  typedef enum logic [1:0] {CS_IDLE, CS_WAIT, CS_WBACK, CS_DONE} ctlState_e;

  ctlState_e stQ, stD;
  busCmd_e   cmdD;
  busCmd_e   missCmd;

  assign missCmd = cpuWrite ? BC_WRMISS : BC_RDMISS;

  always_comb begin
    stD      = stQ;
    strb     = '0;
    busReq   = 1'b0;
    busValid = 1'b0;
    cmdD     = BC_NONE;
    cpuDone  = 1'b0;
    unique case (stQ)
      CS_IDLE: begin
        // a snoop owns the state array this cycle; the cpu waits
        if (cpuReq && !snoopValid) stD = cpuHit ? CS_DONE : CS_WAIT;
      end
      CS_WAIT: begin
        busReq = 1'b1;
        if (restart) begin
          stD = CS_IDLE;
        end else if (busGnt) begin
          busValid = 1'b1;
          if (victimDirty) begin
            cmdD           = BC_WBACK;
            strb.selVictim = 1'b1;
            stD            = CS_WBACK;
          end else begin
            cmdD         = missCmd;
            strb.fill    = 1'b1;
            strb.fillExc = cpuWrite;
            stD          = CS_DONE;
          end
        end
      end
      CS_WBACK: begin
        busReq       = 1'b1;
        busValid     = 1'b1;
        cmdD         = missCmd;
        strb.fill    = 1'b1;
        strb.fillExc = cpuWrite;
        stD          = CS_DONE;
      end
      CS_DONE: begin
        cpuDone = 1'b1;
        stD     = CS_IDLE;
      end
      default: stD = CS_IDLE;
    endcase
  end

  assign busCmd = cmdD;

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= CS_IDLE;
    else       stQ <= stD;
  end

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INDEX_W = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cpuReq,
  input  logic                      cpuWrite,
  input  logic [ADDR_W-1:0]         cpuAddr,
  output logic                      cpuDone,
  output logic                      busReq,
  input  logic                      busGnt,
  output logic                      busValidOut,
  output logic [1:0]                busCmdOut,
  output logic [ADDR_W-1:0]         busAddrOut,
  input  logic                      snoopValid,
  input  logic [1:0]                snoopCmd,
  input  logic [ADDR_W-1:0]         snoopAddr,
  output logic                      supplied,
  input  logic [INDEX_W-1:0]        probeIdx,
  output logic [1:0]                probeState,
  output logic [ADDR_W-INDEX_W-1:0] probeTag
);

  ctlStrobe_t strb;
  logic       cpuHit, victimDirty, restart;

  coh_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuReq     (cpuReq),
    .cpuWrite   (cpuWrite),
    .cpuHit     (cpuHit),
    .victimDirty(victimDirty),
    .restart    (restart),
    .snoopValid (snoopValid),
    .busGnt     (busGnt),
    .strb       (strb),
    .busReq     (busReq),
    .busValid   (busValidOut),
    .busCmd     (busCmdOut),
    .cpuDone    (cpuDone)
  );

  coh_datapath #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cpuWrite   (cpuWrite),
    .cpuAddr    (cpuAddr),
    .snoopValid (snoopValid),
    .snoopCmd   (snoopCmd),
    .snoopAddr  (snoopAddr),
    .strb       (strb),
    .probeIdx   (probeIdx),
    .cpuHit     (cpuHit),
    .victimDirty(victimDirty),
    .restart    (restart),
    .supplied   (supplied),
    .busAddr    (busAddrOut),
    .probeState (probeState),
    .probeTag   (probeTag)
  );

endmodule

// File: rtl/coh_snoop_ctrl_chk.sv
module coh_snoop_ctrl_chk #(
  parameter int ADDR_W  = 8,
  parameter int INDEX_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuDone,
  input logic              busReq,
  input logic              busGnt,
  input logic              busValidOut,
  input logic [1:0]        busCmdOut,
  input logic [ADDR_W-1:0] busAddrOut,
  input logic              snoopValid,
  input logic [1:0]        snoopCmd,
  input logic              supplied
);

  assert_bus_granted_R8: assert property (@(posedge clk) disable iff (!rstN)
    busValidOut |-> (busGnt && busReq));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);

  assert_wback_then_miss_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busValidOut && busCmdOut == 2'b11) |=>
      (busValidOut && (busCmdOut == 2'b01 || busCmdOut == 2'b10)
       && busAddrOut[INDEX_W-1:0] == $past(busAddrOut[INDEX_W-1:0])));

  assert_supply_on_miss_R7: assert property (@(posedge clk) disable iff (!rstN)
    supplied |-> (snoopValid && (snoopCmd == 2'b01 || snoopCmd == 2'b10)));

  assert_no_wb_snoop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && snoopCmd == 2'b11) |-> !supplied);

endmodule

bind coh_snoop_ctrl coh_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cpuDone    (cpuDone),
  .busReq     (busReq),
  .busGnt     (busGnt),
  .busValidOut(busValidOut),
  .busCmdOut  (busCmdOut),
  .busAddrOut (busAddrOut),
  .snoopValid (snoopValid),
  .snoopCmd   (snoopCmd),
  .supplied   (supplied)
);

// File: tb/coh_snoop_ctrl_tb.sv
module coh_snoop_ctrl_tb;

  localparam int AW = 8;
  localparam int IW = 2;
  localparam int TW = AW - IW;

  localparam logic [1:0] ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10;
  localparam logic [1:0] C_RM = 2'b01, C_WM = 2'b10, C_WB = 2'b11;

  // three block addresses sharing index 1
  localparam logic [AW-1:0] A1 = 8'h05, A2 = 8'h09, A3 = 8'h0D;

  logic clk = 1'b0, rstN = 1'b0;
  always #4 clk = ~clk;

  logic          dReq = 0, dWr = 0, pReq = 0, pWr = 0;
  logic [AW-1:0] dAddr = '0, pAddr = '0;
  logic          dDone, pDone, dBusReq, pBusReq, dValid, pValid, dSupp, pSupp;
  logic [1:0]    dCmd, pCmd, dSt, pSt;
  logic [AW-1:0] dBAddr, pBAddr;
  logic [TW-1:0] dTag, pTag;
  logic [IW-1:0] probeIdx = '0;
  logic          gntD, gntP, blockPeer = 1'b0;

  coh_snoop_ctrl #(.ADDR_W(AW), .INDEX_W(IW)) u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(dReq), .cpuWrite(dWr), .cpuAddr(dAddr),
    .cpuDone(dDone), .busReq(dBusReq), .busGnt(gntD), .busValidOut(dValid),
    .busCmdOut(dCmd), .busAddrOut(dBAddr), .snoopValid(pValid),
    .snoopCmd(pCmd), .snoopAddr(pBAddr), .supplied(dSupp),
    .probeIdx(probeIdx), .probeState(dSt), .probeTag(dTag));

  coh_snoop_ctrl #(.ADDR_W(AW), .INDEX_W(IW)) u_peer (
    .clk(clk), .rstN(rstN), .cpuReq(pReq), .cpuWrite(pWr), .cpuAddr(pAddr),
    .cpuDone(pDone), .busReq(pBusReq), .busGnt(gntP), .busValidOut(pValid),
    .busCmdOut(pCmd), .busAddrOut(pBAddr), .snoopValid(dValid),
    .snoopCmd(dCmd), .snoopAddr(dBAddr), .supplied(pSupp),
    .probeIdx(probeIdx), .probeState(pSt), .probeTag(pTag));

  // one grant at a time, held while the owner keeps requesting
  always @(posedge clk) begin
    if (!rstN) begin
      gntD <= 1'b0; gntP <= 1'b0;
    end else if (gntD) gntD <= dBusReq;
    else if (gntP)     gntP <= pBusReq;
    else if (dBusReq)  gntD <= 1'b1;
    else if (pBusReq && !blockPeer) gntP <= 1'b1;
  end

  int nChecks = 0, nFail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard of expected bus transactions
  typedef struct {
    bit         fromPeer;
    logic [1:0] cmd;
    logic [AW-1:0] addr;
    bit         supp;
    string      req;
  } item_t;
  item_t expQ[$];

  task automatic expect_bus(input bit fromPeer, input logic [1:0] cmd,
                            input logic [AW-1:0] addr, input bit supp, input string req);
    item_t it;
    it.fromPeer = fromPeer; it.cmd = cmd; it.addr = addr; it.supp = supp; it.req = req;
    expQ.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rstN && (dValid || pValid)) begin
      item_t it;
      bit fp;
      logic [1:0] c;
      logic [AW-1:0] a;
      bit s;
      check(!(dValid && pValid), "R8", "two drivers on bus", 1, 0);
      fp = pValid;
      c  = fp ? pCmd : dCmd;
      a  = fp ? pBAddr : dBAddr;
      s  = fp ? dSupp : pSupp;
      if (expQ.size() == 0) begin
        check(1'b0, "R8", "unexpected bus command", int'(c), 0);
      end else begin
        it = expQ.pop_front();
        check(fp == it.fromPeer, it.req, "bus source", int'(fp), int'(it.fromPeer));
        check(c == it.cmd, it.req, "bus command", int'(c), int'(it.cmd));
        check(a == it.addr, it.req, "bus address", int'(a), int'(it.addr));
        check(s == it.supp, it.req, "supplied", int'(s), int'(it.supp));
      end
    end
  end

  task automatic access(input bit peer, input bit wr, input logic [AW-1:0] a,
                        input bit expectBus, input string req);
    bit sawReq = 0;
    bit done = 0;
    @(negedge clk);
    if (peer) begin pReq = 1; pWr = wr; pAddr = a; end
    else      begin dReq = 1; dWr = wr; dAddr = a; end
    while (!done) begin
      @(negedge clk);
      sawReq |= peer ? pBusReq : dBusReq;
      done = peer ? pDone : dDone;
    end
    if (peer) pReq = 0; else dReq = 0;
    if (!expectBus) check(!sawReq, req, "bus requested on hit", int'(sawReq), 0);
  endtask

  task automatic check_line(input bit peer, input logic [AW-1:0] a,
                            input logic [1:0] expSt, input string req);
    logic [1:0] st;
    logic [TW-1:0] tg;
    @(negedge clk);
    probeIdx = a[IW-1:0];
    #1;
    st = peer ? pSt : dSt;
    tg = peer ? pTag : dTag;
    check(st == expSt, req, peer ? "peer line state" : "dut line state", int'(st), int'(expSt));
    if (expSt != ST_I)
      check(tg == a[AW-1:IW], req, "line tag", int'(tg), int'(a[AW-1:IW]));
  endtask

  task automatic finish_run();
    check(expQ.size() == 0, "R8", "missing bus commands", expQ.size(), 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      check_line(0, AW'(i), ST_I, "R1");
      check_line(1, AW'(i), ST_I, "R1");
    end
    check(!dBusReq && !dDone, "R1", "busReq/cpuDone after reset", int'({dBusReq, dDone}), 0);

    // step 1: dut writes A1 from Invalid
    expect_bus(0, C_WM, A1, 0, "R3");
    access(0, 1, A1, 1, "R3");
    check_line(0, A1, ST_E, "R3");

    // step 2: hits in Exclusive
    access(0, 0, A1, 0, "R4");
    access(0, 1, A1, 0, "R4");

    // step 3: peer reads A1, dut supplies dirty block
    expect_bus(1, C_RM, A1, 1, "R7");
    access(1, 0, A1, 1, "R2");
    check_line(0, A1, ST_S, "R7");
    check_line(1, A1, ST_S, "R2");
    access(1, 0, A1, 0, "R4");

    // step 4: peer writes A1 held Shared
    expect_bus(1, C_WM, A1, 0, "R3");
    access(1, 1, A1, 1, "R3");
    check_line(1, A1, ST_E, "R3");
    check_line(0, A1, ST_I, "R6");

    // step 5: peer writes A2, evicting dirty A1
    expect_bus(1, C_WB, A1, 0, "R5");
    expect_bus(1, C_WM, A2, 0, "R5");
    access(1, 1, A2, 1, "R5");
    check_line(1, A2, ST_E, "R5");
    check_line(0, A1, ST_I, "R5");

    // dut reads A2 from Invalid, peer supplies
    expect_bus(0, C_RM, A2, 1, "R7");
    access(0, 0, A2, 1, "R2");
    check_line(0, A2, ST_S, "R2");
    check_line(1, A2, ST_S, "R7");

    // dut upgrades A2 Shared -> Exclusive, peer Shared copy dropped
    expect_bus(0, C_WM, A2, 0, "R6");
    access(0, 1, A2, 1, "R3");
    check_line(0, A2, ST_E, "R3");
    check_line(1, A2, ST_I, "R6");

    // peer write-misses A2 held Exclusive by dut
    expect_bus(1, C_WM, A2, 1, "R7");
    access(1, 1, A2, 1, "R3");
    check_line(0, A2, ST_I, "R7");
    check_line(1, A2, ST_E, "R7");

    // R9: peer's write to A3 waits behind dirty A2; a snooped read cleans it
    blockPeer = 1'b1;
    expect_bus(0, C_RM, A2, 1, "R9");
    expect_bus(1, C_WM, A3, 0, "R9");
    fork
      access(1, 1, A3, 1, "R9");
      begin
        repeat (4) @(negedge clk);
        check(pBusReq == 1'b1, "R8", "peer waiting for grant", int'(pBusReq), 1);
        check_line(1, A2, ST_E, "R8");
        access(0, 0, A2, 1, "R9");
        blockPeer = 1'b0;
      end
    join
    check_line(1, A3, ST_E, "R9");
    check_line(0, A2, ST_S, "R7");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule